// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Controller with Edge Interrupts

This block controls a small bank of general-purpose pins from a synchronous register port. Each pin can be set up as an input or an output. An output pin drives a level that software writes. It can also be released to high impedance without changing its direction. An input pin is synchronized. Its sampled level can be inverted before software reads it or the interrupt logic sees it.

Any input pin whose interrupt enable is set raises a sticky pending flag on a rising edge of its synchronized, optionally inverted level. A single interrupt line is the OR of all pending flags. Software clears every pending flag at once by reading the level register. If an edge arrives in the same cycle as that read, the edge is kept.

The host port uses single-cycle write and read strobes. Read data is registered and appears one cycle after the read strobe. The register addresses are 0 for direction, 1 for level, 2 for high impedance, 3 for inversion and 4 for interrupt enable. In every register, bit n belongs to pin n.

Top module: `mpio_ctrl`

## Requirements
- R1: After reset, all five registers read 0x00, pad_oe is all ones, pad_out is all zeros and irq is low.
- R2: A write to address 0, 2, 3 or 4 stores wdata, and a read of that address returns it on rdata in the cycle after the read strobe.
- R3: A write to address 1 drives pad_out with the written value from the next cycle onward. Reading address 1 returns the written bit for pins whose direction bit is 0 (output).
- R4: pad_oe bit n is 1 only when direction bit n is 0 and high-impedance bit n is 0.
- R5: Reading address 1 returns, for pins whose direction bit is 1 (input), the pad level after two synchronizer flops, XORed with inversion bit n.
- R6: When an input pin with its enable bit set sees its synchronized, inverted level go from 0 to 1, irq is high after the third rising clock edge that follows the pad change.
- R7: With inversion bit n set, a falling pad edge raises the interrupt and a rising pad edge does not.
- R8: An edge on a pin whose direction bit is 0, or whose enable bit is 0, never raises irq.
- R9: A pending interrupt stays set until the level register is read. Reads of other addresses leave it set, and a level read with no new edge clears irq in the next cycle.
- R10: A qualifying edge in the same cycle as a clearing level read leaves irq high.
- R11: irq is the OR of the per-pin pending flags. One level read clears the flags of all pins together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data, one bit per pin |
| rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| irq | output | 1 | Interrupt, high while any flag is pending |

## Verification
The bench builds the block with its default eight pins and a two-stage synchronizer. All pins are then visible through 8-bit register values, so every pin can be exercised in one access. The default depth gives a fixed three-edge latency from pad change to interrupt. The bench uses that latency to place a new edge in exactly the same cycle as a clearing read, and to check that the edge wins.

// File: rtl/mpio_pkg.sv
package mpio_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DIR = 3'd0;
  localparam logic [ADDR_W-1:0] A_LVL = 3'd1;
  localparam logic [ADDR_W-1:0] A_HIZ = 3'd2;
  localparam logic [ADDR_W-1:0] A_INV = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN = 3'd4;
endpackage

// File: rtl/mpio_sync.sv
module mpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mpio_regs.sv
module mpio_regs
  import mpio_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  input  logic [NPIN-1:0]   sens,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   hiz_q,
  output logic [NPIN-1:0]   inv_q,
  output logic [NPIN-1:0]   ien_q,
  output logic [NPIN-1:0]   rdata,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe
);
  logic [NPIN-1:0] lvl_q;
  logic [NPIN-1:0] lvl_view;
  logic [NPIN-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      lvl_q <= '0;
      hiz_q <= '0;
      inv_q <= '0;
      ien_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DIR:   dir_q <= wdata;
        A_LVL:   lvl_q <= wdata;
        A_HIZ:   hiz_q <= wdata;
        A_INV:   inv_q <= wdata;
        A_IEN:   ien_q <= wdata;
        default: ;
      endcase
    end
  end

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_view
      assign lvl_view[p] = dir_q[p] ? sens[p] : lvl_q[p];
      assign pad_oe[p]   = ~dir_q[p] & ~hiz_q[p];
    end
  endgenerate

  always_comb begin
    case (addr)
      A_DIR:   rd_mux = dir_q;
      A_LVL:   rd_mux = lvl_view;
      A_HIZ:   rd_mux = hiz_q;
      A_INV:   rd_mux = inv_q;
      A_IEN:   rd_mux = ien_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign pad_out = lvl_q;
endmodule

// File: rtl/mpio_edge.sv
module mpio_edge #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] sens,
  input  logic [NPIN-1:0] dir,
  input  logic [NPIN-1:0] ien,
  input  logic            clear,
  output logic [NPIN-1:0] rise,
  output logic [NPIN-1:0] pend,
  output logic            irq
);
  logic [NPIN-1:0] prev;
  logic [NPIN-1:0] pend_d;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= sens;
  end

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      assign rise[p]   = sens[p] & ~prev[p] & dir[p] & ien[p];
      assign pend_d[p] = rise[p] | (pend[p] & ~clear);
      always_ff @(posedge clk) begin
        if (rst) pend[p] <= 1'b0;
        else     pend[p] <= pend_d[p];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |pend_d;
  end
endmodule

// File: rtl/mpio_ctrl.sv
module mpio_ctrl
  import mpio_pkg::*;
#(
  parameter int NPIN      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  output logic [NPIN-1:0]   rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic              irq
);
  logic [NPIN-1:0] sync_q;
  logic [NPIN-1:0] sens;
  logic [NPIN-1:0] dir_q, hiz_q, inv_q, ien_q;
  logic [NPIN-1:0] rise, pend;
  logic            lvl_clear;

  assign lvl_clear = rd_en && (addr == A_LVL);

  mpio_sync #(.W(NPIN), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_q)
  );

  assign sens = sync_q ^ inv_q;

  mpio_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .sens(sens), .dir_q(dir_q), .hiz_q(hiz_q),
    .inv_q(inv_q), .ien_q(ien_q), .rdata(rdata), .pad_out(pad_out),
    .pad_oe(pad_oe)
  );

  mpio_edge #(.NPIN(NPIN)) u_edge (
    .clk(clk), .rst(rst), .sens(sens), .dir(dir_q), .ien(ien_q),
    .clear(lvl_clear), .rise(rise), .pend(pend), .irq(irq)
  );
endmodule

// File: rtl/mpio_ctrl_chk.sv
module mpio_ctrl_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            lvl_clear,
  input logic [NPIN-1:0] rise,
  input logic [NPIN-1:0] pend,
  input logic [NPIN-1:0] rdata,
  input logic            irq
);
  a_r11_irq_or: assert property (@(posedge clk) disable iff (rst)
    irq == (|pend));
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !lvl_clear) |=> irq);
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (lvl_clear && (rise == '0)) |=> !irq);
  a_r10_edge_wins: assert property (@(posedge clk) disable iff (rst)
    (lvl_clear && (rise != '0)) |=> irq);
  a_r1_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && rdata == '0));
endmodule

bind mpio_ctrl mpio_ctrl_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .lvl_clear(lvl_clear), .rise(rise),
  .pend(pend), .rdata(rdata), .irq(irq)
);

// File: tb/mpio_ctrl_bench.sv
module mpio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, pad_in = '0;
  logic [7:0] rdata, pad_out, pad_oe;
  logic       irq;
  int checks = 0, errors = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  mpio_ctrl u_mpio_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  // {addr, value}: written then read back
  localparam logic [10:0] VEC [8] = '{
    {3'd0, 8'hA5}, {3'd2, 8'h3C}, {3'd3, 8'h81}, {3'd4, 8'hFF},
    {3'd0, 8'h00}, {3'd2, 8'h00}, {3'd3, 8'h00}, {3'd4, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'hFF);
    chk("R1 pad_out", pad_out, 8'h00);
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], got); chk("R1 reg", got, 8'h00);
    end

    // R2 table walk
    foreach (VEC[i]) begin
      wr(VEC[i][10:8], VEC[i][7:0]);
      rd(VEC[i][10:8], got);
      chk("R2 readback", got, VEC[i][7:0]);
    end

    // R3 output level
    wr(3'd1, 8'h5A);
    chk("R3 pad_out", pad_out, 8'h5A);
    rd(3'd1, got); chk("R3 level readback", got, 8'h5A);

    // R4 output enables
    wr(3'd0, 8'h0F); wr(3'd2, 8'h30);
    chk("R4 pad_oe", pad_oe, 8'hC0);

    // R5 input read with inversion
    wr(3'd2, 8'h00); wr(3'd3, 8'h03);
    pad_in = 8'h05; cycles(3);
    rd(3'd1, got); chk("R5 input view", got, 8'h56);
    wr(3'd3, 8'h00); wr(3'd0, 8'h00); pad_in = 8'h00; cycles(3);

    // R8 output pin with enable, and input pin without enable
    wr(3'd4, 8'h02); wr(3'd0, 8'h01);
    pad_in = 8'h03; cycles(4);
    chk("R8 no irq", {7'd0, irq}, 8'h00);
    pad_in = 8'h00; cycles(3);

    // R6 irq latency on pin 0
    wr(3'd4, 8'h01);
    @(negedge clk); pad_in = 8'h01;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R6 not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R6 irq set", {7'd0, irq}, 8'h01);

    // R9 sticky over other reads, cleared by level read
    rd(3'd0, got); rd(3'd4, got); cycles(2);
    chk("R9 sticky", {7'd0, irq}, 8'h01);
    rd(3'd1, got);
    chk("R9 cleared", {7'd0, irq}, 8'h00);
    pad_in = 8'h00; cycles(3);
    chk("R6 falling ignored", {7'd0, irq}, 8'h00);

    // R7 inverted pin 1
    wr(3'd0, 8'h02); wr(3'd4, 8'h02); wr(3'd3, 8'h02);
    pad_in = 8'h02; cycles(3);
    rd(3'd1, got);
    pad_in = 8'h02; cycles(4);
    chk("R7 rising ignored", {7'd0, irq}, 8'h00);
    pad_in = 8'h00; cycles(4);
    chk("R7 falling raises", {7'd0, irq}, 8'h01);
    rd(3'd1, got);
    wr(3'd3, 8'h00); cycles(3); rd(3'd1, got);

    // R10 edge in same cycle as clearing read; R11 OR of pins
    wr(3'd0, 8'h03); wr(3'd4, 8'h03); pad_in = 8'h00; cycles(3); rd(3'd1, got);
    pad_in = 8'h01; cycles(4);
    chk("R11 pin0 pending", {7'd0, irq}, 8'h01);
    @(negedge clk); pad_in = 8'h03;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rd_en = 1'b1; addr = 3'd1;
    @(negedge clk); rd_en = 1'b0;
    chk("R10 edge wins", {7'd0, irq}, 8'h01);
    rd(3'd1, got);
    chk("R11 all cleared", {7'd0, irq}, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule